// File: doc/BRIEF.md
# Memory-Mapped Request Register Slice

This block sits in the request path of a memory-mapped bus that uses waitrequest flow control. Address, write data and the read and write strobes from the manager are captured in a one-deep register and presented to the subordinate one cycle later. Read data and read-data-valid come back from the subordinate to the manager through wires, so the response path gets no extra latency.

Waitrequest is treated as a ready signal with zero ready latency. When it is low, the subordinate takes the access on its port in that cycle. The slice accepts a new access whenever its register is empty, even while the subordinate is stalling. It stalls the manager only when the register is occupied and the subordinate is stalling. A held access leaves as soon as the subordinate stops stalling. If a new access arrives in that same cycle, it is loaded at once, so back-to-back accesses flow with no empty cycle between them.

A parameter turns the slice into plain wires for builds that do not need the extra register.

Top module: `mm_req_slice`

## Requirements
- R1: When `m_write` or `m_read` is high and `m_waitreq` is low at a clock edge, that access (address, write data, both strobes) appears on the `s_*` outputs in the following cycle.
- R2: While the slice holds no access (both `s_write` and `s_read` low), `m_waitreq` is low regardless of `s_waitreq`.
- R3: `m_waitreq` is high exactly when a held access is shown on `s_write`/`s_read` and `s_waitreq` is high.
- R4: While `s_waitreq` is high and an access is held, `s_addr`, `s_wdata`, `s_write` and `s_read` keep their values into the next cycle.
- R5: A held access leaves in the first cycle with `s_waitreq` low. If no new access is accepted in that cycle, both subordinate strobes are low in the next cycle.
- R6: With `s_waitreq` held low and the manager requesting every cycle, a new access is presented to the subordinate in every cycle, with no empty cycle between accesses.
- R7: `m_rdata` and `m_rdvalid` equal `s_rdata` and `s_rdvalid` within the same cycle.
- R8: With `BYPASS` = 1, every `s_*` request output equals its `m_*` input and `m_waitreq` equals `s_waitreq`, in the same cycle.
- R9: An asynchronous reset (`rst_n` low) empties the register at once, with both subordinate strobes low.
- R10: Every accepted access reaches the subordinate exactly once, in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_addr | input | ADDR_W | Manager address |
| m_wdata | input | DATA_W | Manager write data |
| m_write | input | 1 | Manager write strobe |
| m_read | input | 1 | Manager read strobe |
| m_waitreq | output | 1 | Stall toward the manager |
| m_rdata | output | DATA_W | Read data to the manager |
| m_rdvalid | output | 1 | Read data valid to the manager |
| s_addr | output | ADDR_W | Registered address to the subordinate |
| s_wdata | output | DATA_W | Registered write data to the subordinate |
| s_write | output | 1 | Write strobe to the subordinate |
| s_read | output | 1 | Read strobe to the subordinate |
| s_waitreq | input | 1 | Stall from the subordinate |
| s_rdata | input | DATA_W | Read data from the subordinate |
| s_rdvalid | input | 1 | Read data valid from the subordinate |

## Verification
The hardest case to reach from the ports is a single cycle in which the held access drains and a new access loads, while the stall flips around it. This is where a lost access or a duplicated access would appear. The stimulus mixes phases with random stall and request rates, so that this cycle occurs many times. A scoreboard checks order and uniqueness at every drain. A phase with no stalls and a request every cycle checks that there is no empty cycle between accesses. A fully stalled phase fills the register, and the reset is asserted while it is full.

// File: rtl/mm_slice_pkg.sv
package mm_slice_pkg;

  // An access is taken from the manager when a strobe is up and no stall is shown.
  function automatic logic slice_take(input logic wr, input logic rd, input logic up_stall);
    return (wr | rd) & ~up_stall;
  endfunction

  // The held access leaves when the subordinate does not stall.
  function automatic logic slice_drain(input logic full, input logic sub_stall);
    return full & ~sub_stall;
  endfunction

  // Occupancy for the next cycle: a new access, or a held one still stalled.
  function automatic logic slice_fill_next(input logic full, input logic take,
                                           input logic sub_stall);
    return take | (full & sub_stall);
  endfunction

  // The manager is stalled only when the register is full and cannot drain.
  function automatic logic slice_up_stall(input logic full, input logic sub_stall);
    return full & sub_stall;
  endfunction

endpackage

// File: rtl/mm_slice_ctrl.sv
module mm_slice_ctrl
  import mm_slice_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic m_write,
  input  logic m_read,
  input  logic s_waitreq,
  output logic full,
  output logic take,
  output logic drain,
  output logic up_stall
);

  logic full_q;

  assign up_stall = slice_up_stall(full_q, s_waitreq);
  assign take     = slice_take(m_write, m_read, up_stall);
  assign drain    = slice_drain(full_q, s_waitreq);
  assign full     = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= slice_fill_next(full_q, take, s_waitreq);
  end

endmodule

// File: rtl/mm_slice_hold.sv
module mm_slice_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic              in_read,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_write,
  output logic              q_read
);

  localparam int HOLD_W = ADDR_W + DATA_W + 2;

  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= {in_addr, in_wdata, in_write, in_read};
  end

  assign {q_addr, q_wdata, q_write, q_read} = hold_q;

endmodule

// File: rtl/mm_req_slice.sv
module mm_req_slice #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic              m_write,
  input  logic              m_read,
  output logic              m_waitreq,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_rdvalid,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  output logic              s_write,
  output logic              s_read,
  input  logic              s_waitreq,
  input  logic [DATA_W-1:0] s_rdata,
  input  logic              s_rdvalid
);

  // Internal events, named for the checker.
  logic slice_full;
  logic slice_take;
  logic slice_drain;

  // Responses always pass through.
  assign m_rdata   = s_rdata;
  assign m_rdvalid = s_rdvalid;

  generate
    if (BYPASS) begin : g_wire
      assign s_addr      = m_addr;
      assign s_wdata     = m_wdata;
      assign s_write     = m_write;
      assign s_read      = m_read;
      assign m_waitreq   = s_waitreq;
      assign slice_full  = 1'b0;
      assign slice_take  = 1'b0;
      assign slice_drain = 1'b0;
    end else begin : g_reg
      logic up_stall;
      logic h_write;
      logic h_read;

      mm_slice_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_write  (m_write),
        .m_read   (m_read),
        .s_waitreq(s_waitreq),
        .full     (slice_full),
        .take     (slice_take),
        .drain    (slice_drain),
        .up_stall (up_stall)
      );

      mm_slice_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slice_take),
        .in_addr (m_addr),
        .in_wdata(m_wdata),
        .in_write(m_write),
        .in_read (m_read),
        .q_addr  (s_addr),
        .q_wdata (s_wdata),
        .q_write (h_write),
        .q_read  (h_read)
      );

      assign m_waitreq = up_stall;
      assign s_write   = h_write & slice_full;
      assign s_read    = h_read & slice_full;
    end
  endgenerate

endmodule

// File: rtl/mm_req_slice_chk.sv
module mm_req_slice_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_write,
  input logic              m_read,
  input logic              m_waitreq,
  input logic [DATA_W-1:0] m_rdata,
  input logic              m_rdvalid,
  input logic [ADDR_W-1:0] s_addr,
  input logic [DATA_W-1:0] s_wdata,
  input logic              s_write,
  input logic              s_read,
  input logic              s_waitreq,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_rdvalid,
  input logic              slice_full,
  input logic              slice_take,
  input logic              slice_drain
);

  logic s_busy;
  assign s_busy = s_write | s_read;

  p_resp_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rdata == s_rdata) && (m_rdvalid == s_rdvalid));

  generate
    if (BYPASS) begin : g_chk_wire
      p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_addr == m_addr) && (s_wdata == m_wdata) && (s_write == m_write) &&
        (s_read == m_read) && (m_waitreq == s_waitreq));
    end else begin : g_chk_reg
      p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slice_take |=> (s_addr == $past(m_addr)) && (s_wdata == $past(m_wdata)) &&
                       (s_write == $past(m_write)) && (s_read == $past(m_read)));

      p_empty_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_busy |-> !m_waitreq);

      p_stall_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_waitreq |-> s_busy && s_waitreq);

      p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_busy && s_waitreq) |=> $stable(s_addr) && $stable(s_wdata) &&
                                  $stable(s_write) && $stable(s_read));

      p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_drain && !slice_take) |=> !s_write && !s_read);

      p_busy_is_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_busy |-> slice_full);
    end
  endgenerate

  // R9: while reset is held the strobes are already low.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_empty_r9: assert (!s_write && !s_read);
    end
  end

endmodule

bind mm_req_slice mm_req_slice_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYPASS(BYPASS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m_addr     (m_addr),
  .m_wdata    (m_wdata),
  .m_write    (m_write),
  .m_read     (m_read),
  .m_waitreq  (m_waitreq),
  .m_rdata    (m_rdata),
  .m_rdvalid  (m_rdvalid),
  .s_addr     (s_addr),
  .s_wdata    (s_wdata),
  .s_write    (s_write),
  .s_read     (s_read),
  .s_waitreq  (s_waitreq),
  .s_rdata    (s_rdata),
  .s_rdvalid  (s_rdvalid),
  .slice_full (slice_full),
  .slice_take (slice_take),
  .slice_drain(slice_drain)
);

// File: tb/tb_mm_req_slice.sv
module tb_mm_req_slice;

  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          wr;
    logic          rd;
  } acc_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic          m_write = 1'b0, m_read = 1'b0;
  logic          s_waitreq = 1'b0;
  logic [DW-1:0] s_rdata = '0;
  logic          s_rdvalid = 1'b0;

  logic          m_waitreq, m_rdvalid, s_write, s_read;
  logic [DW-1:0] m_rdata, s_wdata;
  logic [AW-1:0] s_addr;

  logic          b_waitreq, b_rdvalid, b_write, b_read;
  logic [DW-1:0] b_rdata, b_wdata;
  logic [AW-1:0] b_addr;

  always #4 clk = ~clk;  // 125 MHz

  mm_req_slice #(.ADDR_W(AW), .DATA_W(DW), .BYPASS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_write(m_write), .m_read(m_read), .m_waitreq(m_waitreq),
    .m_rdata(m_rdata), .m_rdvalid(m_rdvalid), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_write(s_write), .s_read(s_read),
    .s_waitreq(s_waitreq), .s_rdata(s_rdata), .s_rdvalid(s_rdvalid));

  mm_req_slice #(.ADDR_W(AW), .DATA_W(DW), .BYPASS(1'b1)) dut_byp (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_write(m_write), .m_read(m_read), .m_waitreq(b_waitreq),
    .m_rdata(b_rdata), .m_rdvalid(b_rdvalid), .s_addr(b_addr),
    .s_wdata(b_wdata), .s_write(b_write), .s_read(b_read),
    .s_waitreq(s_waitreq), .s_rdata(s_rdata), .s_rdvalid(s_rdvalid));

  int   n_chk = 0;
  int   n_bad = 0;
  acc_t expq[$];
  acc_t cur;
  logic pend = 1'b0;
  acc_t prev_s;
  logic prev_stalled = 1'b0;
  logic prev_drain_only = 1'b0;
  logic prev_accept = 1'b0;

  task automatic check(input string req, input logic ok, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One cycle: drive at the falling edge, check 1 ns later, then wait for the rising edge.
  task automatic cycle(input int req_pct, input int stall_pct, input logic want_busy);
    acc_t s_now;
    logic busy;
    @(negedge clk);
    if (!pend && ($urandom % 100) < req_pct) begin
      cur.addr  = $urandom;
      cur.wdata = $urandom;
      cur.wr    = $urandom % 2;
      cur.rd    = ~cur.wr;
      pend      = 1'b1;
    end
    m_addr    = pend ? cur.addr : '0;
    m_wdata   = pend ? cur.wdata : '0;
    m_write   = pend & cur.wr;
    m_read    = pend & cur.rd;
    s_waitreq = ($urandom % 100) < stall_pct;
    s_rdata   = $urandom;
    s_rdvalid = $urandom % 2;
    #1;
    busy  = s_write | s_read;
    s_now = '{addr: s_addr, wdata: s_wdata, wr: s_write, rd: s_read};
    // R7: response path
    check("R7", (m_rdata == s_rdata) && (m_rdvalid == s_rdvalid), m_rdata, s_rdata);
    // R2/R3: stall only when full and the subordinate stalls
    check(busy ? "R3" : "R2", m_waitreq == (busy & s_waitreq), m_waitreq, busy & s_waitreq);
    // R8: bypass instance is plain wires
    check("R8", (b_addr == m_addr) && (b_wdata == m_wdata) && (b_write == m_write) &&
                (b_read == m_read) && (b_waitreq == s_waitreq) && (b_rdata == s_rdata),
          {b_addr, b_wdata, b_write, b_read, b_waitreq}, {m_addr, m_wdata, m_write, m_read, s_waitreq});
    // R4: held access stable while stalled
    if (prev_stalled) check("R4", s_now == prev_s, s_now, prev_s);
    // R5: after a drain with no new access the strobes are low
    if (prev_drain_only) check("R5", !busy, busy, 1'b0);
    // R1: an access accepted last cycle is presented now
    if (prev_accept) check("R1", busy, busy, 1'b1);
    // R6: back-to-back presentation
    if (want_busy) check("R6", busy, busy, 1'b1);
    // R10 scoreboard: drain compares against the oldest accepted access
    if (busy && !s_waitreq) begin
      if (expq.size() == 0) check("R10", 1'b0, s_now, '0);
      else begin
        acc_t e;
        e = expq.pop_front();
        check("R10", s_now == e, s_now, e);
      end
    end
    prev_stalled    = busy & s_waitreq;
    prev_s          = s_now;
    prev_accept     = pend & ~m_waitreq;
    prev_drain_only = busy & ~s_waitreq & ~prev_accept;
    if (pend && !m_waitreq) begin
      expq.push_back(cur);
      pend = 1'b0;
    end
  endtask

  initial begin
    #1;
    check("R9", !s_write && !s_read && !m_waitreq, {s_write, s_read}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Random traffic with varying pressure
    for (int i = 0; i < 3000; i++) cycle(60, 40, 1'b0);
    for (int i = 0; i < 2000; i++) cycle(95, 80, 1'b0);
    for (int i = 0; i < 2000; i++) cycle(30, 10, 1'b0);

    // R6: no stall, request every cycle
    for (int i = 0; i < 3; i++) cycle(100, 0, 1'b0);
    for (int i = 0; i < 200; i++) cycle(100, 0, 1'b1);

    // Fill the register under a permanent stall, then reset it
    for (int i = 0; i < 5; i++) cycle(100, 100, 1'b0);
    @(negedge clk);
    check("R9", s_write || s_read, {s_write, s_read}, 2'b01);
    rst_n = 1'b0;
    #1;
    check("R9", !s_write && !s_read, {s_write, s_read}, '0);
    check("R2", !m_waitreq, m_waitreq, 1'b0);
    expq.delete();
    pend = 1'b0;
    m_write = 1'b0;
    m_read = 1'b0;
    prev_stalled = 1'b0;
    prev_drain_only = 1'b0;
    prev_accept = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 2000; i++) cycle(70, 50, 1'b0);
    // Drain everything: no stall, no new requests
    while (pend) cycle(0, 0, 1'b0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 1'b0);
    check("R10", expq.size() == 0, expq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    finish_run();
  end

endmodule